// File: doc/BRIEF.md
# Serial Transmit Path with Frame-Format Control

This block turns 9-bit words into asynchronous serial frames on a single output line. Words are written into a 16-entry queue one per clock; whenever the serialiser is free, the oldest word is taken out and sent. It sends a low start bit, then the payload bits lowest first, then a high stop interval. The payload is shaped by a 3-bit format code. That code selects plain 8-bit data, 7-bit data with parity, 8-bit data with parity, 9-bit data, or 8-bit data followed by an address-marker bit. A single control input picks odd or even parity. A 2-bit field sets the stop interval in half-bit steps.

Bit timing comes from an external strobe that pulses sixteen times per bit period; the block has no rate generator of its own. A flow-control input can hold back the start of each new frame. Four status outputs describe the queue and the serialiser, and a flush strobe discards everything still waiting in the queue. The frame being sent when the flush arrives is not affected. Format, parity and stop settings are captured when a frame starts, so they are meant to change only while the line is idle.

Top module: `sertx_top`

## Requirements
- R1: After reset the line output is 1, the all-done flag is 1, the half-free flag is 1, the has-data flag is 0 and the full flag is 0. While no frame is being sent, the line stays 1.
- R2: A frame starts with one 0 bit, followed by the payload bits from bit 0 upward. Each bit lasts exactly 16 pulses of the tick input.
- R3: Format code 1 sends the 8 data bits [7:0]. The unlisted codes 0, 2 and 6 behave the same way, and data bit 8 is not sent.
- R4: Format code 3 sends data bits [6:0] followed by a parity bit, for 8 payload bits. Code 7 sends bits [7:0] followed by a parity bit, for 9 payload bits. With par_odd at 0, the number of ones in the data bits plus the parity bit is even; with par_odd at 1 it is odd.
- R5: Format code 4 sends 9 data bits [8:0]. Code 5 sends bits [7:0] followed by a marker bit equal to data bit 8.
- R6: After the payload, the line is held at 1 for 8, 16, 24 or 32 tick pulses, for stop_sel values 0, 1, 2 and 3. When another word is waiting and sending is allowed, the next start bit begins on the clock right after that interval ends.
- R7: When cts_en is 1, no frame starts while cts_n is 1. When cts_en is 0, cts_n has no effect.
- R8: The full flag is 1 when the queue holds 16 words. The half-free flag is 1 when the queue holds 8 words or fewer. The has-data flag is 1 when the queue holds at least one word. The all-done flag is 1 when the queue is empty and no frame is in progress.
- R9: A word written while the queue is full is dropped and is never sent.
- R10: A flush strobe empties the queue from the next clock, and a write made in the same cycle as the flush is dropped. A frame already being sent completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-clock pulse, 16 per bit period |
| wr_en | input | 1 | Write strobe for wr_data |
| wr_data | input | 9 | Word to queue |
| flush | input | 1 | Discard all queued words |
| fmt_mode | input | 3 | Frame format code |
| stop_sel | input | 2 | Stop interval in half bits, minus one |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| cts_en | input | 1 | Enable flow-control hold-off |
| cts_n | input | 1 | Peer ready, active low |
| txd | output | 1 | Serial line, idle high |
| st_done | output | 1 | Queue empty and serialiser idle |
| st_half | output | 1 | Queue holds half its depth or less |
| st_has | output | 1 | Queue holds at least one word |
| st_full | output | 1 | Queue is full |

## Verification
The hardest situations to create are an over-full write and a flush that lands while a frame is in flight. When the serialiser is running it keeps taking words out of the queue, so neither a full queue nor a mid-frame flush happens by chance. The stimulus first asserts flow control so that nothing starts. It then fills the queue to 16, checks the half-free boundary at 8 and 9 words, and adds a seventeenth word that must not appear on the line. For the flush case, it releases flow control, writes three words back to back, and flushes while the first of them is still being serialised.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  localparam logic [2:0] FMT_D8   = 3'd1;
  localparam logic [2:0] FMT_D7P  = 3'd3;
  localparam logic [2:0] FMT_D9   = 3'd4;
  localparam logic [2:0] FMT_MARK = 3'd5;
  localparam logic [2:0] FMT_D8P  = 3'd7;

  typedef enum logic [1:0] {
    SH_IDLE  = 2'd0,
    SH_START = 2'd1,
    SH_BITS  = 2'd2,
    SH_STOP  = 2'd3
  } shift_state_e;

  // Payload as sent, bit 0 first; unused upper bits are zero.
  function automatic logic [8:0] shape_payload(input logic [2:0] fmt,
                                               input logic [8:0] d,
                                               input logic       odd);
    logic [8:0] p;
    case (fmt)
      FMT_D7P:           p = {1'b0, (^d[6:0]) ^ odd, d[6:0]};
      FMT_D8P:           p = {(^d[7:0]) ^ odd, d[7:0]};
      FMT_D9, FMT_MARK:  p = d;
      default:           p = {1'b0, d[7:0]};
    endcase
    return p;
  endfunction

  function automatic logic [3:0] payload_len(input logic [2:0] fmt);
    logic [3:0] n;
    case (fmt)
      FMT_D8P, FMT_D9, FMT_MARK: n = 4'd9;
      default:                   n = 4'd8;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
  parameter int DW    = 9,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [DW-1:0]              wdata,
  input  logic                       pop,
  output logic [DW-1:0]              rdata,
  output logic [$clog2(DEPTH):0]     count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;

  assign push_ok = push && !flush && (cnt_q != CW'(DEPTH));
  assign pop_ok  = pop  && !flush && (cnt_q != '0);

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (flush) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (push_ok) wptr_d = wptr_q + AW'(1);
      if (pop_ok)  rptr_d = rptr_q + AW'(1);
      case ({push_ok, pop_ok})
        2'b10:   cnt_d = cnt_q + CW'(1);
        2'b01:   cnt_d = cnt_q - CW'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr_q] <= wdata;
  end

  assign rdata = mem[rptr_q];
  assign count = cnt_q;
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
#(
  parameter int TPB = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tick,
  input  logic                         load,
  input  logic [8:0]                   pay,
  input  logic [3:0]                   nbits,
  input  logic [$clog2(2*TPB+1)-1:0]   stop_ticks,
  output logic                         txd,
  output logic                         busy
);
  localparam int STW = $clog2(2*TPB+1);

  shift_state_e   st_q, st_d;
  logic [STW-1:0] tcnt_q, tcnt_d, stop_q, stop_d;
  logic [3:0]     bidx_q, bidx_d, nb_q, nb_d;
  logic [8:0]     sh_q, sh_d;
  logic           txd_q, txd_d;

  always_comb begin
    st_d   = st_q;
    tcnt_d = tcnt_q;
    stop_d = stop_q;
    bidx_d = bidx_q;
    nb_d   = nb_q;
    sh_d   = sh_q;
    txd_d  = txd_q;
    case (st_q)
      SH_IDLE: begin
        txd_d = 1'b1;
        if (load) begin
          st_d   = SH_START;
          tcnt_d = '0;
          sh_d   = pay;
          nb_d   = nbits;
          stop_d = stop_ticks;
          txd_d  = 1'b0;
        end
      end
      SH_START: if (tick) begin
        if (tcnt_q == STW'(TPB-1)) begin
          st_d   = SH_BITS;
          tcnt_d = '0;
          bidx_d = '0;
          txd_d  = sh_q[0];
        end else tcnt_d = tcnt_q + STW'(1);
      end
      SH_BITS: if (tick) begin
        if (tcnt_q == STW'(TPB-1)) begin
          tcnt_d = '0;
          if (bidx_q == nb_q - 4'd1) begin
            st_d  = SH_STOP;
            txd_d = 1'b1;
          end else begin
            bidx_d = bidx_q + 4'd1;
            sh_d   = {1'b0, sh_q[8:1]};
            txd_d  = sh_q[1];
          end
        end else tcnt_d = tcnt_q + STW'(1);
      end
      SH_STOP: if (tick) begin
        if (tcnt_q == stop_q - STW'(1)) st_d = SH_IDLE;
        else                            tcnt_d = tcnt_q + STW'(1);
      end
      default: st_d = SH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SH_IDLE;
      tcnt_q <= '0;
      stop_q <= '0;
      bidx_q <= '0;
      nb_q   <= '0;
      sh_q   <= '0;
      txd_q  <= 1'b1;
    end else begin
      st_q   <= st_d;
      tcnt_q <= tcnt_d;
      stop_q <= stop_d;
      bidx_q <= bidx_d;
      nb_q   <= nb_d;
      sh_q   <= sh_d;
      txd_q  <= txd_d;
    end
  end

  assign txd  = txd_q;
  assign busy = (st_q != SH_IDLE);
endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TPB   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       wr_en,
  input  logic [8:0] wr_data,
  input  logic       flush,
  input  logic [2:0] fmt_mode,
  input  logic [1:0] stop_sel,
  input  logic       par_odd,
  input  logic       cts_en,
  input  logic       cts_n,
  output logic       txd,
  output logic       st_done,
  output logic       st_half,
  output logic       st_has,
  output logic       st_full
);
  localparam int DW  = 9;
  localparam int CW  = $clog2(DEPTH) + 1;
  localparam int STW = $clog2(2*TPB+1);
  localparam int HALF_TICKS = TPB / 2;

  logic [DW-1:0]  head;
  logic [CW-1:0]  fill;
  logic           fr_busy;
  logic           launch;
  logic           peer_ok;
  logic [STW-1:0] stop_len;

  assign peer_ok  = !cts_en || !cts_n;
  assign launch   = !fr_busy && !flush && (fill != '0) && peer_ok;
  assign stop_len = STW'((32'(stop_sel) + 32'd1) * HALF_TICKS);

  sertx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (wr_en),
    .wdata (wr_data),
    .pop   (launch),
    .rdata (head),
    .count (fill)
  );

  sertx_shift #(.TPB(TPB)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick16),
    .load       (launch),
    .pay        (shape_payload(fmt_mode, head, par_odd)),
    .nbits      (payload_len(fmt_mode)),
    .stop_ticks (stop_len),
    .txd        (txd),
    .busy       (fr_busy)
  );

  assign st_has  = (fill != '0);
  assign st_full = (fill == CW'(DEPTH));
  assign st_half = (fill <= CW'(DEPTH/2));
  assign st_done = !st_has && !fr_busy;
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
  input logic clk,
  input logic rst_n,
  input logic tick16,
  input logic cts_en,
  input logic cts_n,
  input logic flush,
  input logic txd,
  input logic st_done,
  input logic st_half,
  input logic st_has,
  input logic st_full,
  input logic busy
);
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd); // R1

  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && !$past(tick16)) |-> $stable(txd)); // R2

  AST_PEER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!cts_en || !cts_n)); // R7

  AST_FULL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    st_full |-> (st_has && !st_half && !st_done)); // R8

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    st_done |-> (!busy && !st_has && st_half)); // R8

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!st_has && !st_full)); // R10
endmodule

bind sertx_top sertx_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick16  (tick16),
  .cts_en  (cts_en),
  .cts_n   (cts_n),
  .flush   (flush),
  .txd     (txd),
  .st_done (st_done),
  .st_half (st_half),
  .st_has  (st_has),
  .st_full (st_full),
  .busy    (fr_busy)
);

// File: tb/sertx_top_test.sv
module sertx_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick16;
  logic       wr_en;
  logic [8:0] wr_data;
  logic       flush;
  logic [2:0] fmt_mode;
  logic [1:0] stop_sel;
  logic       par_odd;
  logic       cts_en;
  logic       cts_n;
  logic       txd, st_done, st_half, st_has, st_full;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [8:0] qp[$];
  int         qn[$];
  int         qs[$];
  string      qt[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sertx_top uut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .wr_en(wr_en), .wr_data(wr_data),
    .flush(flush), .fmt_mode(fmt_mode), .stop_sel(stop_sel), .par_odd(par_odd),
    .cts_en(cts_en), .cts_n(cts_n), .txd(txd), .st_done(st_done),
    .st_half(st_half), .st_has(st_has), .st_full(st_full)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
    end
  endtask

  // tick source
  initial begin
    int div = 0;
    tick16 = 1'b0;
    forever begin
      @(negedge clk);
      div = (div + 1) % TICK_DIV;
      tick16 = (div == 0);
    end
  end

  task automatic wr(input logic [8:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // driver: expected frame from the requirements, then the write
  task automatic send(input logic [8:0] d, input string tag);
    logic [8:0] p;
    int n;
    case (fmt_mode)
      3'd3: begin p = {1'b0, (^d[6:0]) ^ par_odd, d[6:0]}; n = 8; end
      3'd7: begin p = {(^d[7:0]) ^ par_odd, d[7:0]}; n = 9; end
      3'd4, 3'd5: begin p = d; n = 9; end
      default: begin p = {1'b0, d[7:0]}; n = 8; end
    endcase
    qp.push_back(p);
    qn.push_back(n);
    qs.push_back((int'(stop_sel) + 1) * 8);
    qt.push_back(tag);
    wr(d);
  endtask

  task automatic drain();
    do @(negedge clk); while (!(st_done && qp.size() == 0));
    repeat (5) @(negedge clk);
  endtask

  // monitor: compares line levels with queued frames
  initial begin
    logic [8:0] cp;
    int cn, cs, cnt, idx;
    string ct;
    bit active, tk, b2b;
    logic expv;
    active = 0; b2b = 0; cnt = 0; cn = 0; cs = 0; cp = '0; ct = "";
    forever begin
      @(posedge clk);
      tk = tick16;
      #1;
      if (rst_n !== 1'b1) begin
        active = 0; b2b = 0;
      end else if (!active) begin
        if (b2b) begin
          chk(txd == 1'b0, "R6 next start right after stop", int'(txd), 0);
          b2b = 0;
        end
        if (txd == 1'b0) begin
          if (qp.size() == 0) begin
            chk(1'b0, "R9/R10 unexpected frame on line", 0, 1);
          end else begin
            cp = qp.pop_front(); cn = qn.pop_front();
            cs = qs.pop_front(); ct = qt.pop_front();
            active = 1; cnt = 0;
          end
        end
      end else if (tk) begin
        cnt++;
        if (cnt % 16 == 8) begin
          idx = cnt / 16;
          if (idx == 0) expv = 1'b0;
          else if (idx <= cn) expv = cp[idx-1];
          else expv = 1'b1;
          if (idx == 0)       chk(txd == expv, "R2 start bit", int'(txd), int'(expv));
          else if (idx <= cn) chk(txd == expv, ct, int'(txd), int'(expv));
          else                chk(txd == expv, "R6 stop level", int'(txd), int'(expv));
        end
        if (cnt == 16*(cn+1) + cs - 1)
          chk(txd == 1'b1, "R6 stop still high", int'(txd), 1);
        if (cnt == 16*(cn+1) + cs) begin
          active = 0;
          b2b = (qp.size() > 0) && (!cts_en || !cts_n);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; flush = 1'b0;
    fmt_mode = 3'd1; stop_sel = 2'd1; par_odd = 1'b0;
    cts_en = 1'b0; cts_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(txd == 1'b1,     "R1 reset line", int'(txd), 1);
    chk(st_done == 1'b1, "R1 reset done flag", int'(st_done), 1);
    chk(st_half == 1'b1, "R1 reset half flag", int'(st_half), 1);
    chk(st_has == 1'b0,  "R1 reset has flag", int'(st_has), 0);
    chk(st_full == 1'b0, "R1 reset full flag", int'(st_full), 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(txd == 1'b1, "R1 idle line", int'(txd), 1);

    // 8-bit frames, peer input ignored since cts_en=0 (R7)
    send(9'h05A, "R3 R7 8-bit data");
    send(9'h0C3, "R3 8-bit data");
    send(9'h101, "R3 8-bit data bit8 dropped");
    drain();
    fmt_mode = 3'd0;
    send(9'h1FF, "R3 unlisted code 0");
    drain();
    fmt_mode = 3'd6;
    send(9'h12C, "R3 unlisted code 6");
    drain();

    // parity formats
    fmt_mode = 3'd3; par_odd = 1'b0;
    send(9'h035, "R4 7-bit even");
    send(9'h0B4, "R4 7-bit even");
    drain();
    par_odd = 1'b1;
    send(9'h035, "R4 7-bit odd");
    drain();
    fmt_mode = 3'd7; par_odd = 1'b0;
    send(9'h0A7, "R4 8-bit even");
    drain();
    par_odd = 1'b1;
    send(9'h0A7, "R4 8-bit odd");
    send(9'h000, "R4 8-bit odd zero");
    drain();
    par_odd = 1'b0;

    // 9-bit and marker formats
    fmt_mode = 3'd4;
    send(9'h1A5, "R5 9-bit data");
    send(9'h0F0, "R5 9-bit data");
    drain();
    fmt_mode = 3'd5;
    send(9'h155, "R5 marker bit set");
    send(9'h0AA, "R5 marker bit clear");
    drain();

    // stop lengths, back to back
    fmt_mode = 3'd1;
    for (int s = 0; s < 4; s++) begin
      stop_sel = 2'(s);
      send(9'(8'h3C + s), "R6 stop length frame");
      send(9'(8'h81 + s), "R6 stop length frame");
      drain();
    end
    stop_sel = 2'd1;

    // hold-off, fill, over-full write
    cts_en = 1'b1; cts_n = 1'b1;
    for (int i = 0; i < 16; i++) begin
      send(9'(i * 23 + 1), "R9 queued frame");
      if (i == 7) chk(st_half == 1'b1, "R8 half at 8 words", int'(st_half), 1);
      if (i == 8) chk(st_half == 1'b0, "R8 half at 9 words", int'(st_half), 0);
    end
    chk(st_full == 1'b1, "R8 full at 16", int'(st_full), 1);
    chk(st_has == 1'b1,  "R8 has at 16", int'(st_has), 1);
    chk(st_done == 1'b0, "R8 done at 16", int'(st_done), 0);
    wr(9'h0EE);
    chk(st_full == 1'b1, "R9 still full after extra write", int'(st_full), 1);
    repeat (300) @(negedge clk);
    chk(txd == 1'b1, "R7 no frame while peer not ready", int'(txd), 1);
    chk(st_full == 1'b1, "R7 queue untouched while held", int'(st_full), 1);
    cts_n = 1'b0;
    drain();
    chk(st_done == 1'b1 && st_has == 1'b0, "R8 done after drain", int'(st_done), 1);

    // flush during a frame
    send(9'h011, "R10 frame in flight");
    send(9'h022, "R10 flushed");
    send(9'h033, "R10 flushed");
    @(negedge clk); flush = 1'b1;
    wr_en = 1'b1; wr_data = 9'h044;
    @(negedge clk); flush = 1'b0; wr_en = 1'b0;
    chk(st_has == 1'b0,  "R10 queue empty after flush", int'(st_has), 0);
    chk(st_done == 1'b0, "R10 frame still running", int'(st_done), 0);
    while (qp.size() > 0) begin
      void'(qp.pop_back()); void'(qn.pop_back());
      void'(qs.pop_back()); void'(qt.pop_back());
    end
    drain();
    repeat (400) @(negedge clk);
    chk(txd == 1'b1 && st_done == 1'b1, "R10 nothing after flush", int'(txd), 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule